// File: doc/BRIEF.md
# Global Trigger Mask and Lockout Unit

The unit receives 26 already-discriminated trigger lines. Each line is a single-cycle pulse in the system clock domain. The lines are gated by a programmable mask. Any masked-in line that fires while the unit is idle issues a global trigger: a one-cycle strobe, the trigger ID and a trigger word.

After each trigger the unit stays locked out for a programmable number of cycles. Any masked-in activity during that window is blocked and recorded in a missed-trigger bit of the word. The unit also derives a prescaled copy of the low-threshold hit line and keeps a running trigger ID. The ID can emit a synchronous-clear pulse each time its low 16 bits wrap.

The lockout width, the prescale ratio and the ID preset value are taken from their data inputs. Each load happens only when the matching load-toggle input changes level, in either direction.

Top module: `gtrig_unit`

## Requirements
- R1: A line whose mask bit is 0 causes no global trigger.
- R2: A masked-in line issues `gt_o` for exactly one cycle, one clock after the pulse. `trig_word_o[25:0]` then holds the masked lines of that cycle, and bit 26 is 0.
- R3: Let L be the loaded width, or 1 when the width is 0. The L cycles after a trigger accept no trigger. A pulse on the cycle after that window is accepted. `lock_done_o` pulses once, on the last cycle of the window.
- R4: A masked-in pulse inside the lockout window sets `trig_word_o[26]`. That bit is final when `lock_done_o` pulses.
- R5: The trigger ID increments once per issued trigger. A blocked pulse leaves it unchanged.
- R6: The lockout width loads from `lock_width_i` only when `lock_tgl_i` changes level. A new data value with a steady toggle input has no effect.
- R7: Line 11 is driven internally. It fires on every Nth raw pulse of line 0, whether or not line 0 is masked in. N is loaded on a change of `presc_tgl_i`, N=0 acts as 1, and the reset value of N is 1. The external `trig_i[11]` is ignored.
- R8: A change of `id_tgl_i` presets the ID. The next trigger carries `id_preset_i`, and counting continues from there.
- R9: `sync_clr_o` pulses together with `gt_o` when `resync_en_i` is 1 and the issued ID has low 16 bits of all ones. It does not pulse when `resync_en_i` is 0.
- R10: After reset all outputs are 0, the ID is 0 and the lockout width is 4.
- R11: The software line (bit 25) triggers through the mask like any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 26 | Discriminated trigger pulses; bit 11 unused |
| mask_i | input | 26 | 1 = line masked in |
| resync_en_i | input | 1 | Enable sync clear on 16-bit ID wrap |
| lock_tgl_i | input | 1 | Toggle to load lockout width |
| lock_width_i | input | LOCK_W | Lockout width in cycles |
| presc_tgl_i | input | 1 | Toggle to load prescale ratio |
| presc_ratio_i | input | PRESC_W | Prescale ratio N |
| id_tgl_i | input | 1 | Toggle to preset trigger ID |
| id_preset_i | input | ID_W | Preset trigger ID value |
| gt_o | output | 1 | Global trigger strobe |
| gt_id_o | output | ID_W | ID of the last issued trigger |
| trig_word_o | output | 27 | Fired lines plus missed bit 26 |
| sync_clr_o | output | 1 | Synchronous clear on ID wrap |
| lock_done_o | output | 1 | Last cycle of lockout window |

## Verification
The hardest situation to reach is the exact edge of the lockout window. A pulse on the final locked cycle must set the missed bit. A pulse on the very next cycle must issue a fresh trigger. The stimulus drives per-cycle pulse patterns at widths 4, 1 and 0 to hit both sides of that boundary. The 16-bit wrap is reached by presetting the ID just below 0xFFFF instead of counting up to it.

// File: rtl/gtrig_pkg.sv
package gtrig_pkg;
  localparam int NUM_TRIG   = 26;
  localparam int WORD_W     = 27;
  localparam int LOW_HIT    = 0;
  localparam int PRESC_LINE = 11;
  localparam int MISS_BIT   = 26;
  localparam int ROLL_W     = 16;
endpackage

// File: rtl/gtrig_toggle.sv
module gtrig_toggle #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign edge_o = lvl_i ^ prev_q;
endmodule

// File: rtl/gtrig_prescaler.sv
module gtrig_prescaler #(
  parameter int CNT_W = 16,
  parameter int RST_N = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic             src_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] n_q, cnt_q, n_m1;
  logic             last;

  assign n_m1   = (n_q == '0) ? '0 : n_q - 1'b1;
  assign last   = (cnt_q >= n_m1);
  assign fire_o = src_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= CNT_W'(RST_N);
      cnt_q <= '0;
    end else if (load_i) begin
      n_q   <= ratio_i;
      cnt_q <= '0;
    end else if (src_i) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gtrig_lockout.sv
module gtrig_lockout #(
  parameter int CNT_W = 16,
  parameter int RST_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             start_i,
  input  logic             hit_i,
  output logic             busy_o,
  output logic             missed_o,
  output logic             done_o
);
  logic [CNT_W-1:0] w_q, cnt_q, len;

  // zero width still blocks one cycle
  assign len      = (w_q == '0) ? CNT_W'(1) : w_q;
  assign busy_o   = (cnt_q != '0);
  assign missed_o = busy_o & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= CNT_W'(RST_W);
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      if (load_i) w_q <= width_i;
      done_o <= busy_o && (cnt_q == CNT_W'(1));
      if (start_i)     cnt_q <= len;
      else if (busy_o) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/gtrig_id_ctr.sv
module gtrig_id_ctr #(
  parameter int ID_W   = 24,
  parameter int ROLL_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            preset_i,
  input  logic [ID_W-1:0] preset_val_i,
  input  logic            adv_i,
  output logic [ID_W-1:0] id_o,
  output logic            wrap_o
);
  logic [ID_W-1:0] id_q;

  assign id_o   = id_q;
  assign wrap_o = adv_i & (&id_q[ROLL_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       id_q <= '0;
    else if (preset_i) id_q <= preset_val_i;
    else if (adv_i)    id_q <= id_q + 1'b1;
  end
endmodule

// File: rtl/gtrig_unit.sv
module gtrig_unit
  import gtrig_pkg::*;
#(
  parameter int ID_W      = 24,
  parameter int LOCK_W    = 16,
  parameter int PRESC_W   = 16,
  parameter int LOCK_RST  = 4,
  parameter int PRESC_RST = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [NUM_TRIG-1:0] mask_i,
  input  logic                resync_en_i,
  input  logic                lock_tgl_i,
  input  logic [LOCK_W-1:0]   lock_width_i,
  input  logic                presc_tgl_i,
  input  logic [PRESC_W-1:0]  presc_ratio_i,
  input  logic                id_tgl_i,
  input  logic [ID_W-1:0]     id_preset_i,
  output logic                gt_o,
  output logic [ID_W-1:0]     gt_id_o,
  output logic [WORD_W-1:0]   trig_word_o,
  output logic                sync_clr_o,
  output logic                lock_done_o
);
  localparam int NTGL = 3;
  localparam int T_LOCK = 0, T_PRESC = 1, T_ID = 2;

  logic [NTGL-1:0]     tgl_edge;
  logic                presc_fire;
  logic [NUM_TRIG-1:0] lines, masked_lines;
  logic                hit, accept, lock_busy, missed;
  logic [ID_W-1:0]     id_cur;
  logic                id_wrap;
  logic                unused_raw_presc;

  assign unused_raw_presc = trig_i[PRESC_LINE];

  gtrig_toggle #(.W(NTGL)) u_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({id_tgl_i, presc_tgl_i, lock_tgl_i}),
    .edge_o (tgl_edge)
  );

  gtrig_prescaler #(.CNT_W(PRESC_W), .RST_N(PRESC_RST)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tgl_edge[T_PRESC]),
    .ratio_i (presc_ratio_i),
    .src_i   (trig_i[LOW_HIT]),
    .fire_o  (presc_fire)
  );

  // line 11 comes from the prescaler, not the pin
  always_comb begin
    lines             = trig_i;
    lines[PRESC_LINE] = presc_fire;
  end

  assign masked_lines = lines & mask_i;
  assign hit          = |masked_lines;
  assign accept       = hit & ~lock_busy;

  gtrig_lockout #(.CNT_W(LOCK_W), .RST_W(LOCK_RST)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tgl_edge[T_LOCK]),
    .width_i  (lock_width_i),
    .start_i  (accept),
    .hit_i    (hit),
    .busy_o   (lock_busy),
    .missed_o (missed),
    .done_o   (lock_done_o)
  );

  gtrig_id_ctr #(.ID_W(ID_W), .ROLL_W(ROLL_W)) u_id (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .preset_i     (tgl_edge[T_ID]),
    .preset_val_i (id_preset_i),
    .adv_i        (accept),
    .id_o         (id_cur),
    .wrap_o       (id_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gt_o        <= 1'b0;
      gt_id_o     <= '0;
      trig_word_o <= '0;
      sync_clr_o  <= 1'b0;
    end else begin
      gt_o       <= accept;
      sync_clr_o <= id_wrap & resync_en_i;
      if (accept) begin
        gt_id_o     <= id_cur;
        trig_word_o <= {1'b0, masked_lines};
      end else if (missed) begin
        trig_word_o[MISS_BIT] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gtrig_unit_chk.sv
module gtrig_unit_chk #(
  parameter int ID_W = 24
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [25:0] masked_lines,
  input logic        lock_busy,
  input logic        gt_o,
  input logic [ID_W-1:0] gt_id_o,
  input logic [26:0] trig_word_o,
  input logic        sync_clr_o,
  input logic        lock_done_o
);
  p_gt_needs_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gt_o |-> $past(|masked_lines));
  p_gt_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gt_o |=> !gt_o);
  p_word_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gt_o |-> !trig_word_o[26]);
  p_gt_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gt_o |-> !$past(lock_busy));
  p_done_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_done_o |-> !lock_busy);
  p_missed_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_word_o[26]) |-> $past(lock_busy));
  p_id_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gt_o |-> $stable(gt_id_o));
  p_sync_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_o |-> gt_o && (&gt_id_o[15:0]));
endmodule

bind gtrig_unit gtrig_unit_chk #(.ID_W(ID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .masked_lines (masked_lines),
  .lock_busy    (lock_busy),
  .gt_o         (gt_o),
  .gt_id_o      (gt_id_o),
  .trig_word_o  (trig_word_o),
  .sync_clr_o   (sync_clr_o),
  .lock_done_o  (lock_done_o)
);

// File: tb/gtrig_unit_bench.sv
`timescale 1ns/1ps
module gtrig_unit_bench;
  localparam int MISS = 26;

  typedef struct {
    logic [23:0] id;
    logic [26:0] word;
    logic        sync;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [25:0] trig = '0, mask = '0;
  logic        resync = 0, lock_tgl = 0, presc_tgl = 0, id_tgl = 0;
  logic [15:0] lock_w = '0, presc_n = '0;
  logic [23:0] id_pre = '0;
  logic        gt, sync_clr, done;
  logic [23:0] gt_id;
  logic [26:0] word;

  exp_t        exp_q[$];
  logic [26:0] done_q[$];
  int n_chk = 0, n_fail = 0, n_gt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gtrig_unit u_gtrig_unit (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .mask_i(mask),
    .resync_en_i(resync), .lock_tgl_i(lock_tgl), .lock_width_i(lock_w),
    .presc_tgl_i(presc_tgl), .presc_ratio_i(presc_n),
    .id_tgl_i(id_tgl), .id_preset_i(id_pre),
    .gt_o(gt), .gt_id_o(gt_id), .trig_word_o(word),
    .sync_clr_o(sync_clr), .lock_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [25:0] v);
    trig = v;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) drive('0);
  endtask

  task automatic push(input logic [23:0] id, input logic [26:0] w, input logic s);
    exp_t e;
    e.id = id; e.word = w; e.sync = s;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (gt) begin
        n_gt++;
        if (exp_q.size() == 0) chk(0, "R2 unexpected trigger", 32'(word), 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(gt_id == e.id, "R5 id", 32'(gt_id), 32'(e.id));
          chk(word == (e.word & ~(27'd1 << MISS)), "R2 word", 32'(word), 32'(e.word & ~(27'd1 << MISS)));
          chk(sync_clr == e.sync, "R9 sync", 32'(sync_clr), 32'(e.sync));
          done_q.push_back(e.word);
        end
      end else if (sync_clr) chk(0, "R9 sync without trigger", 1, 0);
      if (done) begin
        if (done_q.size() == 0) chk(0, "R3 unexpected done", 1, 0);
        else begin
          logic [26:0] w;
          w = done_q.pop_front();
          chk(word == w, "R4 word at done", 32'(word), 32'(w));
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    chk(gt == 0 && word == 0 && sync_clr == 0 && done == 0 && gt_id == 0, "R10 reset", 32'(word), 0);
    rst_n = 1;
    mask = 26'h3FF_FFFF & ~(26'd1 << 3);
    idle(2);

    // R1 masked-out line
    drive(26'd1 << 3); idle(8);
    chk(n_gt == 0, "R1 masked out", n_gt, 0);

    // R2 single line
    push(0, 27'd1 << 5, 0); drive(26'd1 << 5); idle(8);
    // R7 prescale N=1 (reset value) adds line 11
    push(1, 27'h803, 0); drive(26'h3); idle(8);

    // R11 software line, R3/R4 window edge with width 4
    push(2, (27'd1 << 25) | (27'd1 << MISS), 0);
    push(3, 27'd1 << 6, 0);
    drive(26'd1 << 25); idle(3); drive(26'd1 << 6); drive(26'd1 << 6); idle(10);
    chk(n_gt == 4, "R3 boundary count", n_gt, 4);

    // R6 data change without toggle keeps width 4
    lock_w = 16'd1; idle(3);
    push(4, (27'd1 << 7) | (27'd1 << MISS), 0);
    drive(26'd1 << 7); idle(2); drive(26'd1 << 7); idle(10);
    chk(n_gt == 5, "R6 level ignored", n_gt, 5);
    lock_tgl = 1; idle(2);
    push(5, (27'd1 << 8) | (27'd1 << MISS), 0);
    push(6, 27'd1 << 8, 0);
    drive(26'd1 << 8); drive(26'd1 << 8); drive(26'd1 << 8); idle(8);
    chk(n_gt == 7, "R6 width 1 loaded", n_gt, 7);

    // R3 width 0 acts as 1
    lock_w = 16'd0; lock_tgl = 0; idle(2);
    push(7, (27'd1 << 9) | (27'd1 << MISS), 0);
    drive(26'd1 << 9); drive(26'd1 << 9); idle(8);
    chk(n_gt == 8, "R3 width 0", n_gt, 8);

    // R7 prescale N=3, line 0 masked out
    mask = 26'd1 << 11; presc_n = 16'd3; presc_tgl = 1; idle(2);
    g = 0;
    for (int i = 1; i <= 6; i++) begin
      if (i % 3 == 0) begin push(24'(8 + g), 27'd1 << 11, 0); g++; end
      drive(26'd1); idle(7);
    end
    chk(n_gt == 10, "R7 one in three", n_gt, 10);
    drive(26'd1 << 11); idle(7);
    chk(n_gt == 10, "R7 raw line 11 ignored", n_gt, 10);
    presc_n = 16'd0; presc_tgl = 0; idle(2);
    push(10, 27'd1 << 11, 0); drive(26'd1); idle(7);
    push(11, 27'd1 << 11, 0); drive(26'd1); idle(7);
    chk(n_gt == 12, "R7 N=0 every pulse", n_gt, 12);

    // R8 preset, R9 wrap with resync enabled
    mask = 26'h3FF_FFFF; id_pre = 24'h00FFFE; resync = 1; id_tgl = 1; idle(2);
    push(24'h00FFFE, 27'd1 << 4, 0); drive(26'd1 << 4); idle(8);
    push(24'h00FFFF, 27'd1 << 4, 1); drive(26'd1 << 4); idle(8);
    push(24'h010000, 27'd1 << 4, 0); drive(26'd1 << 4); idle(8);
    // R9 disabled
    resync = 0; id_pre = 24'h12FFFF; id_tgl = 0; idle(2);
    push(24'h12FFFF, 27'd1 << 4, 0); drive(26'd1 << 4); idle(8);

    chk(exp_q.size() == 0, "R2 pending triggers", exp_q.size(), 0);
    chk(done_q.size() == 0, "R3 pending done", done_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule